// File: doc/BRIEF.md
# Nibble-Accessed Reload Timer

This block is an 8-bit down-counter paired with an 8-bit reload register, sized for a 4-bit processor core whose data path moves one nibble at a time. Software reaches it through a command strobe carrying a two-bit opcode and two 4-bit data ports. The low port carries bits 3..0 and the high port carries bits 7..4. Software can read the count, write the counter and the reload register together, write only the reload register, or test the timer's request flag. The test raises a skip pulse so the core can jump over its next instruction.

The counter steps down by one on every cycle in which the count-enable input is high. A step taken from zero is an underflow: the counter reloads and the request flag is set. The flag test only acts when the interrupt-enable input is low. In that case it skips if the flag was set and clears the flag. When interrupt-enable is high, the flag is left to the interrupt logic and the test behaves as a no-operation.

Top module: `nrt_timer`

## Requirements
- R1: After reset the counter, the reload register, the request flag, the skip output and both read-data nibbles are all 0.
- R2: A command with opcode 2'b00 (read) captures the count as it stood before that clock edge. From the next cycle, `b_out` shows count bits 7..4 and `a_out` shows bits 3..0.
- R3: A command with opcode 2'b01 (load both) writes `{b_in, a_in}` into the counter and into the reload register at the same edge.
- R4: A command with opcode 2'b10 (load reload) writes `{b_in, a_in}` into the reload register only. The counter is left as it was, apart from its normal counting.
- R5: On each cycle with `cnt_en` high and no load-both command, a nonzero counter decreases by exactly one.
- R6: On a cycle with `cnt_en` high, a counter at 0 and no load-both command, the counter takes the reload value and the request flag becomes 1.
- R7: A command with opcode 2'b11 (flag test) while `intr_en` is 0 drives `skip` high for the next cycle exactly when the flag was 1, and clears the flag.
- R8: A flag test while `intr_en` is 1 leaves the flag unchanged and keeps `skip` low.
- R9: If an underflow and a flag-clearing test fall on the same edge, the flag stays 1 (setting wins). The skip still reflects the flag's earlier value.
- R10: A load-both command on a cycle with `cnt_en` high loads the written value with no decrement. No underflow and no flag set come from that cycle.
- R11: An underflow on the same edge as a load-reload command refills the counter from the reload value held before that edge. The new reload value is used from the next underflow on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable: one decrement per high cycle |
| intr_en | input | 1 | Interrupt-enable bit for this timer. High makes the flag test a no-operation |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Opcode: 00 read, 01 load both, 10 load reload, 11 flag test |
| a_in | input | 4 | Write data, low nibble |
| b_in | input | 4 | Write data, high nibble |
| a_out | output | 4 | Read data, count bits 3..0 |
| b_out | output | 4 | Read data, count bits 7..4 |
| skip | output | 1 | One-cycle skip request after a flag test |
| flag | output | 1 | Timer request flag |

## Verification
The assertions take for granted that every input is a known 0 or 1 on each rising edge once reset is released. They also assume at most one command per cycle, which the single strobe and opcode field enforce. Under those assumptions the assertions reason about the next state purely from the opcode, `cnt_en`, `intr_en` and the current count. The bench changes every input only at the falling clock edge and always drives defined values. It releases reset between edges, so no assertion ever sees a half-settled input.

// File: rtl/nrt_pkg.sv
package nrt_pkg;

    typedef enum logic [1:0] {
        OP_READ        = 2'b00,
        OP_LOAD_BOTH   = 2'b01,
        OP_LOAD_RELOAD = 2'b10,
        OP_TEST_FLAG   = 2'b11
    } nrt_op_e;

endpackage

// File: rtl/nrt_cmd_decode.sv
module nrt_cmd_decode
    import nrt_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       rd_stb,
    output logic       ld_both_stb,
    output logic       ld_rel_stb,
    output logic       test_stb
);

    always_comb begin
        rd_stb      = 1'b0;
        ld_both_stb = 1'b0;
        ld_rel_stb  = 1'b0;
        test_stb    = 1'b0;
        if (cmd_valid) begin
            unique case (nrt_op_e'(cmd_op))
                OP_READ:        rd_stb      = 1'b1;
                OP_LOAD_BOTH:   ld_both_stb = 1'b1;
                OP_LOAD_RELOAD: ld_rel_stb  = 1'b1;
                OP_TEST_FLAG:   test_stb    = 1'b1;
                default:        rd_stb      = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/nrt_count_path.sv
module nrt_count_path #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count_q,
    input  logic [CNT_W-1:0] reload_q,
    input  logic [CNT_W-1:0] wr_value,
    input  logic             cnt_en,
    input  logic             ld_both,
    input  logic             ld_rel,
    output logic [CNT_W-1:0] count_d,
    output logic [CNT_W-1:0] reload_d,
    output logic             underflow
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic at_zero;

    assign at_zero = (count_q == ZERO);

    always_comb begin
        count_d   = count_q;
        reload_d  = reload_q;
        underflow = 1'b0;
        if (ld_both) begin
            count_d  = wr_value;
            reload_d = wr_value;
        end else begin
            if (ld_rel) begin
                reload_d = wr_value;
            end
            if (cnt_en) begin
                if (at_zero) begin
                    count_d   = reload_q;
                    underflow = 1'b1;
                end else begin
                    count_d = count_q - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/nrt_flag_path.sv
module nrt_flag_path (
    input  logic flag_q,
    input  logic underflow,
    input  logic test_stb,
    input  logic intr_en,
    output logic flag_d,
    output logic skip_d
);

    logic test_active;

    assign test_active = test_stb && !intr_en;

    always_comb begin
        skip_d = test_active && flag_q;
        flag_d = flag_q;
        if (test_active) begin
            flag_d = 1'b0;
        end
        if (underflow) begin
            flag_d = 1'b1;
        end
    end

endmodule

// File: rtl/nrt_timer.sv
module nrt_timer #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             intr_en,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [NIB_W-1:0] a_in,
    input  logic [NIB_W-1:0] b_in,
    output logic [NIB_W-1:0] a_out,
    output logic [NIB_W-1:0] b_out,
    output logic             skip,
    output logic             flag
);

    localparam int CNT_W = 2 * NIB_W;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] rd_data;
        logic             flag;
        logic             skip;
    } state_t;

    state_t st_d, st_q;

    logic             rd_stb, ld_both_stb, ld_rel_stb, test_stb;
    logic [CNT_W-1:0] wr_value;
    logic [CNT_W-1:0] count_nx, reload_nx;
    logic             underflow;
    logic             flag_nx, skip_nx;

    assign wr_value = {b_in, a_in};

    nrt_cmd_decode u_dec (
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .rd_stb      (rd_stb),
        .ld_both_stb (ld_both_stb),
        .ld_rel_stb  (ld_rel_stb),
        .test_stb    (test_stb)
    );

    nrt_count_path #(.CNT_W(CNT_W)) u_cnt (
        .count_q   (st_q.count),
        .reload_q  (st_q.reload),
        .wr_value  (wr_value),
        .cnt_en    (cnt_en),
        .ld_both   (ld_both_stb),
        .ld_rel    (ld_rel_stb),
        .count_d   (count_nx),
        .reload_d  (reload_nx),
        .underflow (underflow)
    );

    nrt_flag_path u_flg (
        .flag_q    (st_q.flag),
        .underflow (underflow),
        .test_stb  (test_stb),
        .intr_en   (intr_en),
        .flag_d    (flag_nx),
        .skip_d    (skip_nx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.count   = count_nx;
        st_d.reload  = reload_nx;
        st_d.flag    = flag_nx;
        st_d.skip    = skip_nx;
        if (rd_stb) begin
            st_d.rd_data = st_q.count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign b_out = st_q.rd_data[CNT_W-1:NIB_W];
    assign a_out = st_q.rd_data[NIB_W-1:0];
    assign skip  = st_q.skip;
    assign flag  = st_q.flag;

endmodule

// File: rtl/nrt_timer_chk.sv
module nrt_timer_chk #(
    parameter int NIB_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cnt_en,
    input logic               intr_en,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic [NIB_W-1:0]   a_in,
    input logic [NIB_W-1:0]   b_in,
    input logic               skip,
    input logic               flag,
    input logic [2*NIB_W-1:0] count_q,
    input logic [2*NIB_W-1:0] reload_q
);

    localparam int CNT_W = 2 * NIB_W;

    logic is_both, is_rel, is_test;
    assign is_both = cmd_valid && (cmd_op == 2'b01);
    assign is_rel  = cmd_valid && (cmd_op == 2'b10);
    assign is_test = cmd_valid && (cmd_op == 2'b11);

    AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        is_both |=> (count_q == $past({b_in, a_in})) && (reload_q == $past({b_in, a_in}))); // R3

    AST_RELOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rel && !cnt_en) |=> (count_q == $past(count_q)) && (reload_q == $past({b_in, a_in}))); // R4

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !is_both && count_q != '0) |=> count_q == CNT_W'($past(count_q) - 1'b1)); // R5

    AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !is_both && count_q == '0) |=> flag && (count_q == $past(reload_q))); // R6

    AST_TEST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_test && !intr_en && !(cnt_en && count_q == '0)) |=> !flag && (skip == $past(flag))); // R7

    AST_TEST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_test && intr_en) |=> !skip); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_test && !intr_en && cnt_en && count_q == '0) |=> flag); // R9

    AST_SKIP_NEEDS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        !is_test |=> !skip); // R7

endmodule

bind nrt_timer nrt_timer_chk #(.NIB_W(NIB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .intr_en   (intr_en),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .a_in      (a_in),
    .b_in      (b_in),
    .skip      (skip),
    .flag      (flag),
    .count_q   (st_q.count),
    .reload_q  (st_q.reload)
);

// File: tb/nrt_timer_test.sv
`timescale 1ns/1ps
module nrt_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       intr_en = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [3:0] a_in = 4'h0;
    logic [3:0] b_in = 4'h0;
    logic [3:0] a_out, b_out;
    logic       skip, flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [1:0] C_RD = 2'b00, C_BOTH = 2'b01, C_REL = 2'b10, C_TST = 2'b11;

    always #2 clk = ~clk;

    nrt_timer uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .intr_en(intr_en),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .b_out(b_out), .skip(skip), .flag(flag)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // one clock: inputs set at a falling edge, results visible at the next falling edge
    task automatic step(input bit v, input logic [1:0] op, input logic [7:0] val,
                        input bit en, input bit ie);
        cmd_valid = v; cmd_op = op; b_in = val[7:4]; a_in = val[3:0];
        cnt_en = en; intr_en = ie;
        @(negedge clk);
        cmd_valid = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic read_count(input string tag, input logic [7:0] exp);
        step(1, C_RD, 8'h00, 0, 0);
        check({tag, " hi"}, b_out, exp[7:4]);
        check({tag, " lo"}, a_out, exp[3:0]);
    endtask

    task automatic t_reset;
        check("R1 flag", flag, 0);
        check("R1 skip", skip, 0);
        check("R1 rd lo", a_out, 0);
        check("R1 rd hi", b_out, 0);
        read_count("R1 count", 8'h00);
    endtask

    task automatic t_load_and_read;
        step(1, C_BOTH, 8'h5A, 0, 0);
        read_count("R2 R3 load", 8'h5A);
        read_count("R2 reread", 8'h5A);
    endtask

    task automatic t_decrement;
        step(0, C_RD, 8'h00, 1, 0);
        step(0, C_RD, 8'h00, 1, 0);
        step(0, C_RD, 8'h00, 1, 0);
        read_count("R5 decrement", 8'h57);
        check("R5 no flag", flag, 0);
    endtask

    task automatic t_reload_only_and_underflow;
        step(1, C_BOTH, 8'h02, 0, 0);
        step(1, C_REL, 8'h33, 0, 0);
        read_count("R4 count kept", 8'h02);
        step(0, C_RD, 8'h00, 1, 0);
        step(0, C_RD, 8'h00, 1, 0);
        check("R6 no flag at zero", flag, 0);
        step(0, C_RD, 8'h00, 1, 0);
        check("R6 flag set", flag, 1);
        read_count("R6 R4 reload value", 8'h33);
    endtask

    task automatic t_flag_test;
        step(1, C_TST, 8'h00, 0, 1);
        check("R8 skip low", skip, 0);
        check("R8 flag kept", flag, 1);
        step(1, C_TST, 8'h00, 0, 0);
        check("R7 skip", skip, 1);
        check("R7 flag cleared", flag, 0);
        step(0, C_RD, 8'h00, 0, 0);
        check("R7 skip one cycle", skip, 0);
        step(1, C_TST, 8'h00, 0, 0);
        check("R7 no skip when clear", skip, 0);
    endtask

    task automatic t_set_wins;
        step(1, C_BOTH, 8'h00, 0, 0);
        step(0, C_RD, 8'h00, 1, 0);
        check("R9 flag pre", flag, 1);
        step(1, C_TST, 8'h00, 1, 0);
        check("R9 skip", skip, 1);
        check("R9 flag held", flag, 1);
    endtask

    task automatic t_write_beats_count;
        step(1, C_TST, 8'h00, 0, 0);
        check("R10 flag pre", flag, 0);
        step(1, C_BOTH, 8'h44, 1, 0);
        check("R10 no flag", flag, 0);
        read_count("R10 written value", 8'h44);
    endtask

    task automatic t_reload_during_underflow;
        step(1, C_BOTH, 8'h01, 0, 0);
        step(0, C_RD, 8'h00, 1, 0);
        step(1, C_REL, 8'h77, 1, 0);
        check("R11 flag", flag, 1);
        read_count("R11 old reload", 8'h01);
        step(1, C_TST, 8'h00, 0, 0);
        step(0, C_RD, 8'h00, 1, 0);
        step(0, C_RD, 8'h00, 1, 0);
        read_count("R11 new reload", 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_and_read();
        t_decrement();
        t_reload_only_and_underflow();
        t_flag_test();
        t_set_wins();
        t_write_beats_count();
        t_reload_during_underflow();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule